// File: doc/BRIEF.md
# Programmable Product-Term Chip-Select Decoder

This block turns the upper address bits of a microcontroller bus, a set of page-register bits, a few general-purpose inputs and the bus strobes into a bank of active-low chip-selects. Each select comes from one or more programmable AND-terms. For every input, a term can demand a high level, demand a low level or ignore that input. Some selects then OR a fixed number of those terms together. The outputs are eight memory-bank selects, one RAM select, one I/O-port select, three direction selects for a multiplexed address/data port, and eleven external selects that can be routed to pins.

Software programs the terms through a plain synchronous register-write port. A further register picks the role of the topmost input. In address mode it is an ordinary decoder input. In chip-select mode, driving it high deselects every output and raises a power-down flag. Reset deselects every output at once and clears the configuration. Reset can never appear inside a term. All select outputs are combinational functions of the inputs and the stored configuration.

Top module: `pt_decoder`

## Requirements
- R1: While `rst` is high, and after reset until any term is programmed, every select output is 1 (inactive) and `pwr_dn` is 0, for every input pattern.
- R2: Term word encoding: bit 2i set requires input i high, bit 2i+1 set requires input i low, both set makes the term never match, neither set ignores input i; bit 2·NIN is the term enable, and a disabled term never matches. Input index order is addr_hi (0..7), page (8..11), gpi (12..15), rd (16), wr (17), ale (18), top_in (19).
- R3: Term t (0..7) alone drives bank_sel_n[t]; term 8 alone drives ram_sel_n; term 9 alone drives io_sel_n; each output is 0 exactly when its term matches.
- R4: ext_sel_n[k] for k=0..3 is 0 when any of terms 13+4k .. 16+4k matches.
- R5: ext_sel_n[k] for k=4..7 is 0 when term 29+2(k-4) or the term after it matches; ext_sel_n[k] for k=8..10 follows term 37+(k-8) alone.
- R6: din_sel_n is 0 only when term 10 matches and rd is 1; dout1_sel_n is 0 only when term 11 matches and ale is 1; dout2_sel_n follows term 12 alone.
- R7: In address mode (mode register 0) top_in is input 19 of every term.
- R8: In chip-select mode (mode register 1) top_in high forces every select to 1 and sets `pwr_dn`; with top_in low the top_in mask bits of every term are ignored and `pwr_dn` is 0.
- R9: A write with cfg_addr below 40 stores cfg_wdata as that term's word from the next cycle on; cfg_addr 40 loads the mode register from cfg_wdata[0]; writes to higher addresses change nothing.
- R10: A reset raised mid-run deselects all outputs at once and leaves every term disabled and the mode register at 0 (address mode) after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset; also deselects all outputs |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Term index (0..39) or mode register (40) |
| cfg_wdata | input | 41 | Term word or mode bit |
| addr_hi | input | 8 | Upper address bits |
| page | input | 4 | Page-register bits |
| gpi | input | 4 | General-purpose inputs |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| ale | input | 1 | Address-latch strobe, active high |
| top_in | input | 1 | Top address bit or power-down chip-select |
| bank_sel_n | output | 8 | Memory-bank selects, active low |
| ram_sel_n | output | 1 | RAM select, active low |
| io_sel_n | output | 1 | I/O-port select, active low |
| din_sel_n | output | 1 | Port input-direction select, active low |
| dout1_sel_n | output | 1 | Port address-output select, active low |
| dout2_sel_n | output | 1 | Port data-output select, active low |
| ext_sel_n | output | 11 | Routable external selects, active low |
| pwr_dn | output | 1 | Power-down flag |

## Verification
The bench builds the decoder with its default widths: eight address bits, four page bits and four general-purpose inputs, which gives 20 term inputs and 40 terms. Together the upper address bits and the top input span only 512 values, so every value of that pair can be swept against several term programs. The other inputs and the masks are drawn at random and biased toward "ignore", so that multi-term OR groups and gated direction selects are hit often. Both top-input modes and a mid-run reset are covered against an arithmetic reference model.

// File: rtl/pt_dec_pkg.sv
`timescale 1ns/1ps
package pt_dec_pkg;

    localparam int N_BANK  = 8;
    localparam int N_EXT   = 11;

    // Fixed term positions of the single-term outputs
    localparam int T_RAM   = 8;
    localparam int T_IO    = 9;
    localparam int T_DIN   = 10;
    localparam int T_DOUT1 = 11;
    localparam int T_DOUT2 = 12;
    localparam int T_EXT0  = 13;

    // Product-term budget of external select k: 4, 2 or 1 terms
    function automatic int ext_terms(input int k);
        if (k < 4)      return 4;
        else if (k < 8) return 2;
        else            return 1;
    endfunction

    function automatic int ext_base(input int k);
        int b;
        b = T_EXT0;
        for (int j = 0; j < k; j++) b += ext_terms(j);
        return b;
    endfunction

    localparam int N_TERMS = ext_base(N_EXT);

    typedef enum logic {
        MODE_ADDR = 1'b0,
        MODE_CSI  = 1'b1
    } top_mode_e;

    typedef struct packed {
        logic [N_BANK-1:0] bank_n;
        logic              ram_n;
        logic              io_n;
        logic              din_n;
        logic              dout1_n;
        logic              dout2_n;
        logic [N_EXT-1:0]  ext_n;
    } sel_t;

endpackage

// File: rtl/pt_cfg_regs.sv
`timescale 1ns/1ps
module pt_cfg_regs
    import pt_dec_pkg::*;
#(
    parameter int NIN = 20,
    parameter int AW  = 6,
    localparam int CFG_W = 2 * NIN + 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we_i,
    input  logic [AW-1:0]                  addr_i,
    input  logic [CFG_W-1:0]               wdata_i,
    output logic [N_TERMS-1:0][CFG_W-1:0]  cfg_o,
    output top_mode_e                      mode_o
);

    logic [N_TERMS-1:0][CFG_W-1:0] cfg_q;
    top_mode_e                     mode_q;

    for (genvar t = 0; t < N_TERMS; t++) begin : g_term_reg
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[t] <= '0;
            else if (we_i && (addr_i == AW'(t)))
                cfg_q[t] <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_ADDR;
        else if (we_i && (addr_i == AW'(N_TERMS)))
            mode_q <= top_mode_e'(wdata_i[0]);
    end

    assign cfg_o  = cfg_q;
    assign mode_o = mode_q;

    assert_cfg_clear_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode_q == MODE_ADDR && cfg_q == '0));

    assert_ign_addr_R9: assert property (@(posedge clk) disable iff (rst)
        (we_i && (addr_i > AW'(N_TERMS))) |=> ($stable(cfg_q) && $stable(mode_q)));

endmodule

// File: rtl/pt_term.sv
`timescale 1ns/1ps
module pt_term #(
    parameter int NIN = 20,
    localparam int CFG_W = 2 * NIN + 1
) (
    input  logic [NIN-1:0]   x_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             ign_top_i,
    output logic             hit_o
);

    always_comb begin
        hit_o = cfg_i[CFG_W-1];
        for (int i = 0; i < NIN; i++) begin
            if (!(ign_top_i && (i == NIN - 1))) begin
                if (cfg_i[2*i] && !x_i[i])   hit_o = 1'b0;
                if (cfg_i[2*i+1] && x_i[i])  hit_o = 1'b0;
            end
        end
    end

endmodule

// File: rtl/pt_out_map.sv
`timescale 1ns/1ps
module pt_out_map
    import pt_dec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [N_TERMS-1:0] hit_i,
    input  logic               rd_i,
    input  logic               ale_i,
    input  logic               force_off_i,
    output sel_t               sel_n_o
);

    logic [N_EXT-1:0] ext_hit;
    sel_t             raw;

    for (genvar k = 0; k < N_EXT; k++) begin : g_ext
        assign ext_hit[k] = |hit_i[ext_base(k) +: ext_terms(k)];
    end

    always_comb begin
        raw.bank_n  = ~hit_i[N_BANK-1:0];
        raw.ram_n   = ~hit_i[T_RAM];
        raw.io_n    = ~hit_i[T_IO];
        raw.din_n   = ~(hit_i[T_DIN] & rd_i);
        raw.dout1_n = ~(hit_i[T_DOUT1] & ale_i);
        raw.dout2_n = ~hit_i[T_DOUT2];
        raw.ext_n   = ~ext_hit;
        sel_n_o     = force_off_i ? '1 : raw;
    end

    assert_din_gate_R6: assert property (@(posedge clk) disable iff (rst)
        !rd_i |-> sel_n_o.din_n);

    assert_dout1_gate_R6: assert property (@(posedge clk) disable iff (rst)
        !ale_i |-> sel_n_o.dout1_n);

endmodule

// File: rtl/pt_decoder.sv
`timescale 1ns/1ps
module pt_decoder
    import pt_dec_pkg::*;
#(
    parameter int N_ADDR = 8,
    parameter int N_PAGE = 4,
    parameter int N_GPI  = 4,
    localparam int NIN   = N_ADDR + N_PAGE + N_GPI + 4,
    localparam int CFG_W = 2 * NIN + 1,
    localparam int AW    = $clog2(N_TERMS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [N_ADDR-1:0] addr_hi,
    input  logic [N_PAGE-1:0] page,
    input  logic [N_GPI-1:0]  gpi,
    input  logic              rd,
    input  logic              wr,
    input  logic              ale,
    input  logic              top_in,
    output logic [N_BANK-1:0] bank_sel_n,
    output logic              ram_sel_n,
    output logic              io_sel_n,
    output logic              din_sel_n,
    output logic              dout1_sel_n,
    output logic              dout2_sel_n,
    output logic [N_EXT-1:0]  ext_sel_n,
    output logic              pwr_dn
);

    logic [N_TERMS-1:0][CFG_W-1:0] term_cfg;
    top_mode_e                     mode;
    logic [NIN-1:0]                x;
    logic [N_TERMS-1:0]            hit;
    logic                          csi_off;
    sel_t                          sel_n;

    assign x = {top_in, ale, wr, rd, gpi, page, addr_hi};

    pt_cfg_regs #(.NIN(NIN), .AW(AW)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we_i    (cfg_we),
        .addr_i  (cfg_addr),
        .wdata_i (cfg_wdata),
        .cfg_o   (term_cfg),
        .mode_o  (mode)
    );

    for (genvar t = 0; t < N_TERMS; t++) begin : g_terms
        pt_term #(.NIN(NIN)) u_term (
            .x_i       (x),
            .cfg_i     (term_cfg[t]),
            .ign_top_i (mode == MODE_CSI),
            .hit_o     (hit[t])
        );
    end

    assign csi_off = (mode == MODE_CSI) && top_in;
    assign pwr_dn  = !rst && csi_off;

    pt_out_map u_map (
        .clk         (clk),
        .rst         (rst),
        .hit_i       (hit),
        .rd_i        (rd),
        .ale_i       (ale),
        .force_off_i (rst || csi_off),
        .sel_n_o     (sel_n)
    );

    assign bank_sel_n  = sel_n.bank_n;
    assign ram_sel_n   = sel_n.ram_n;
    assign io_sel_n    = sel_n.io_n;
    assign din_sel_n   = sel_n.din_n;
    assign dout1_sel_n = sel_n.dout1_n;
    assign dout2_sel_n = sel_n.dout2_n;
    assign ext_sel_n   = sel_n.ext_n;

    assert_pd_deselect_R8: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |-> (&bank_sel_n && ram_sel_n && io_sel_n && din_sel_n &&
                    dout1_sel_n && dout2_sel_n && &ext_sel_n));

endmodule

// File: tb/pt_decoder_tb_top.sv
`timescale 1ns/1ps
module pt_decoder_tb_top;

    localparam int NT = 40;
    localparam int NI = 20;
    localparam int CW = 41;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [40:0] cfg_wdata = '0;
    logic [7:0]  addr_hi = '0;
    logic [3:0]  page = '0;
    logic [3:0]  gpi = '0;
    logic        rd = 1'b0, wr = 1'b0, ale = 1'b0, top_in = 1'b0;
    logic [7:0]  bank_sel_n;
    logic        ram_sel_n, io_sel_n, din_sel_n, dout1_sel_n, dout2_sel_n;
    logic [10:0] ext_sel_n;
    logic        pwr_dn;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [CW-1:0] m [NT];
    logic          b_mode = 1'b0;
    logic          b_rst  = 1'b1;
    logic [NI-1:0] cur_x  = '0;

    always #2.5 clk = ~clk;

    pt_decoder dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .addr_hi(addr_hi), .page(page), .gpi(gpi),
        .rd(rd), .wr(wr), .ale(ale), .top_in(top_in),
        .bank_sel_n(bank_sel_n), .ram_sel_n(ram_sel_n), .io_sel_n(io_sel_n),
        .din_sel_n(din_sel_n), .dout1_sel_n(dout1_sel_n),
        .dout2_sel_n(dout2_sel_n), .ext_sel_n(ext_sel_n), .pwr_dn(pwr_dn)
    );

    wire [23:0] act = {bank_sel_n, ram_sel_n, io_sel_n, din_sel_n,
                       dout1_sel_n, dout2_sel_n, ext_sel_n};

    function automatic bit ref_term(int t, logic [NI-1:0] xv);
        bit ok;
        ok = m[t][2*NI];
        for (int i = 0; i < NI; i++) begin
            if (!(b_mode && i == NI - 1)) begin
                if (m[t][2*i]   && !xv[i]) ok = 1'b0;
                if (m[t][2*i+1] &&  xv[i]) ok = 1'b0;
            end
        end
        return ok;
    endfunction

    function automatic logic [23:0] ref_sel(logic [NI-1:0] xv);
        logic [NT-1:0] h;
        logic [10:0]   e;
        for (int t = 0; t < NT; t++) h[t] = ref_term(t, xv);
        for (int k = 0; k < 11; k++) begin
            if (k < 4)      e[k] = h[13+4*k] | h[14+4*k] | h[15+4*k] | h[16+4*k];
            else if (k < 8) e[k] = h[29+2*(k-4)] | h[30+2*(k-4)];
            else            e[k] = h[37+(k-8)];
        end
        if (b_rst || (b_mode && xv[19])) return '1;
        return {~h[7:0], ~h[8], ~h[9], ~(h[10] & xv[16]), ~(h[11] & xv[18]),
                ~h[12], ~e};
    endfunction

    task automatic drive(logic [NI-1:0] xv);
        cur_x = xv;
        {top_in, ale, wr, rd, gpi, page, addr_hi} = xv;
    endtask

    task automatic check(string tag);
        logic [23:0] es;
        logic        ep;
        es = ref_sel(cur_x);
        ep = !b_rst && b_mode && cur_x[19];
        checks++;
        if (act !== es || pwr_dn !== ep) begin
            errors++;
            $display("FAIL %s x=%h sel=%h exp=%h pwr_dn=%b exp=%b",
                     tag, cur_x, act, es, pwr_dn, ep);
        end
    endtask

    task automatic apply(string tag, logic [NI-1:0] xv);
        @(negedge clk);
        drive(xv);
        #1;
        check(tag);
    endtask

    task automatic wcfg(int a, logic [CW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = 6'(a);
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < NT) m[a] = d;
        else if (a == NT) b_mode = d[0];
    endtask

    function automatic logic [CW-1:0] rnd_word();
        logic [CW-1:0] w;
        w = '0;
        for (int i = 0; i < NI; i++) begin
            int r;
            r = $urandom % 24;
            if (r == 0) w[2*i] = 1'b1;
            else if (r == 1) w[2*i+1] = 1'b1;
            else if (r == 2 && ($urandom % 4 == 0)) begin
                w[2*i] = 1'b1;
                w[2*i+1] = 1'b1;
            end
        end
        w[2*NI] = ($urandom % 8) != 0;
        return w;
    endfunction

    task automatic prog_all();
        for (int t = 0; t < NT; t++) wcfg(t, rnd_word());
    endtask

    task automatic sweep(string tag, int n);
        for (int v = 0; v < n; v++) apply(tag, NI'($urandom));
    endtask

    initial begin
        #500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] w;
        for (int t = 0; t < NT; t++) m[t] = '0;

        // R1 R10: outputs inactive during reset
        repeat (3) @(negedge clk);
        for (int v = 0; v < 6; v++) apply("R1 R10 in reset", NI'($urandom));
        @(negedge clk);
        rst = 1'b0;
        b_rst = 1'b0;

        // R1: unprogrammed decoder selects nothing
        sweep("R1 unprogrammed", 20);

        // R2: encoding of one term (bank 0, input 0 = addr_hi[0])
        w = '0; w[2*NI] = 1'b1; w[0] = 1'b1;
        wcfg(0, w);
        for (int v = 0; v < 8; v++) apply("R2 true", NI'($urandom));
        apply("R2 true hi", 20'h00001);
        apply("R2 true lo", 20'h00000);
        w = '0; w[2*NI] = 1'b1; w[1] = 1'b1;
        wcfg(0, w);
        apply("R2 compl hi", 20'h00001);
        apply("R2 compl lo", 20'h00000);
        w = '0; w[2*NI] = 1'b1; w[0] = 1'b1; w[1] = 1'b1;
        wcfg(0, w);
        apply("R2 never hi", 20'h00001);
        apply("R2 never lo", 20'h00000);
        w = '0; w[2*NI] = 1'b1;
        wcfg(0, w);
        sweep("R2 enabled dont-care", 8);
        w = '0; w[2] = 1'b1;
        wcfg(0, w);
        sweep("R2 disabled", 8);
        // Every input position, one at a time, on term 1
        for (int i = 0; i < NI; i++) begin
            w = '0; w[2*NI] = 1'b1; w[2*i] = 1'b1;
            wcfg(1, w);
            apply("R2 position hi", NI'(1) << i);
            apply("R2 position lo", ~(NI'(1) << i));
        end
        wcfg(1, '0);

        // R3 R4 R5 R6: random programs, random vectors
        for (int r = 0; r < 8; r++) begin
            prog_all();
            sweep("R3 R4 R5 R6 random", 200);
        end

        // R6: direction gating with strobes held
        w = '0; w[2*NI] = 1'b1;
        wcfg(10, w); wcfg(11, w); wcfg(12, w);
        apply("R6 rd=0 ale=0", 20'h00000);
        apply("R6 rd=1", 20'h10000);
        apply("R6 ale=1", 20'h40000);

        // R7: exhaustive over addr_hi and top_in in address mode
        prog_all();
        w = '0; w[2*NI] = 1'b1; w[2*19] = 1'b1; w[2*7+1] = 1'b1;
        wcfg(9, w);
        for (int v = 0; v < 512; v++) begin
            logic [NI-1:0] xv;
            xv = NI'($urandom);
            xv[7:0] = v[7:0];
            xv[19]  = v[8];
            apply("R7 address mode", xv);
        end

        // R8: chip-select mode
        wcfg(NT, 41'd1);
        prog_all();
        w = '0; w[2*NI] = 1'b1; w[2*19+1] = 1'b1;
        wcfg(9, w);
        apply("R8 top low", 20'h00000);
        apply("R8 top high", 20'h80000);
        sweep("R8 csi mode", 300);

        // R9: out-of-range writes ignored, mode write back to address
        wcfg(41, {CW{1'b1}});
        wcfg(63, {CW{1'b1}});
        sweep("R9 ignored address", 50);
        wcfg(NT, 41'd0);
        sweep("R9 mode cleared", 50);

        // R10: reset mid-run
        prog_all();
        @(negedge clk);
        rst = 1'b1;
        b_rst = 1'b1;
        #1;
        check("R10 immediate deselect");
        for (int v = 0; v < 4; v++) apply("R10 held", NI'($urandom));
        @(negedge clk);
        rst = 1'b0;
        b_rst = 1'b0;
        for (int t = 0; t < NT; t++) m[t] = '0;
        b_mode = 1'b0;
        apply("R10 after release top high", 20'hFFFFF);
        sweep("R10 after release", 20);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule